// File: doc/BRIEF.md
# Processor Low-Power State Sequencer

This block follows the power state of a processor core through six states: Normal, Auto Halt, Quick Start, Snoop Service, Deep Sleep and Deeper Sleep. It watches a halt request, a quick-start (stop-grant) request, a snoop strobe and its completion, a bus-clock-running flag, an active-low deep-sleep request and a flag from the voltage regulator saying the core voltage has been lowered. From these it drives a one-hot state vector, a flag that allows snoops, a core clock enable and a request to the regulator for reduced voltage.

A snoop that arrives while the core is halted or in Quick Start is serviced in a dedicated state. When the snoop is done the machine goes back to the state it came from. Deep Sleep is reached from Quick Start by exactly one of two triggers: the bus clock stopping, or the deep-sleep input going low. Waking from Deep Sleep waits out a programmable PLL relock delay, counted in cycles of the free-running reference clock. Deeper Sleep is Deep Sleep at the lowered voltage, and the core context is kept in both. Illegal input combinations set a sticky error flag.

Top module: `pwr_state_seq`

## Requirements
- R1: `stateOneHot` always has exactly one bit set. The bit positions are: bit0 Normal, bit1 Auto Halt, bit2 Quick Start, bit3 Snoop Service, bit4 Deep Sleep, bit5 Deeper Sleep.
- R2: In Normal, `quickReq` moves the machine to Quick Start, and it wins over `haltReq`. Otherwise `haltReq` moves it to Auto Halt. Auto Halt returns to Normal when `haltReq` is low. Quick Start returns to Normal when `quickReq` is low and nothing else applies.
- R3: When `snoopReq` is high in Auto Halt or in Quick Start, the next state is Snoop Service. In Quick Start the snoop takes priority over a deep-sleep trigger in the same cycle.
- R4: Snoop Service holds while `snoopDone` is low. On `snoopDone` it returns to exactly the state it was entered from.
- R5: In Snoop Service entered from Quick Start, a deep-sleep trigger (`busClkRun` low or `deepSleepN` low) is a violation. It sets `errFlag` and does not change the state.
- R6: In Quick Start with no snoop, exactly one active trigger moves the machine to Deep Sleep. Both triggers at once keep it in Quick Start and set `errFlag`.
- R7: In Deep Sleep, when both triggers have been released, the relock count is loaded with RELOCK_CYCLES. Quick Start is entered exactly RELOCK_CYCLES cycles after the cycle in which the release was first seen. A trigger that returns during relock cancels the count.
- R8: Deep Sleep with a trigger still active and no relock in progress goes to Deeper Sleep when `lowVoltOk` is high. Deeper Sleep goes back to Deep Sleep when `lowVoltOk` is low. `vrLowReq` is high only while a trigger is active and the state is either Deeper Sleep or Deep Sleep with no relock in progress.
- R9: A `snoopReq` in Deep Sleep or Deeper Sleep does not change the state and sets `errFlag`.
- R10: Synchronous active-high `rst` gives Normal, a cleared relock count and `errFlag` low.
- R11: `coreClkEn` is high only in Normal. `snoopOk` is low only in Deep Sleep and Deeper Sleep.
- R12: Once set, `errFlag` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| haltReq | input | 1 | Halt request |
| quickReq | input | 1 | Stop-grant / quick-start request |
| snoopReq | input | 1 | Snoop request strobe |
| snoopDone | input | 1 | Snoop finished and bus idle |
| busClkRun | input | 1 | Bus clock is running |
| deepSleepN | input | 1 | Active-low deep-sleep request |
| lowVoltOk | input | 1 | Regulator reports lowered core voltage |
| stateOneHot | output | 6 | One-hot current state |
| snoopOk | output | 1 | Snoops may be serviced |
| coreClkEn | output | 1 | Core clock enable |
| vrLowReq | output | 1 | Request for reduced core voltage |
| errFlag | output | 1 | Sticky protocol-violation flag |

## Verification
Two events can fall in the same cycle in Quick Start: a snoop request and a deep-sleep trigger. The bench raises `snoopReq` and drops `busClkRun` on the same edge. It expects Snoop Service with the error flag still low, because the snoop wins and no rule has yet been broken. On the next cycle the trigger is still held while the snoop is in service, and the bench then expects the error flag to rise with the state unchanged. The relock window is checked cycle by cycle after release, and again on the second trigger.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [2:0] {
    PS_NORMAL = 3'd0,
    PS_HALT   = 3'd1,
    PS_QUICK  = 3'd2,
    PS_SNOOP  = 3'd3,
    PS_DEEP   = 3'd4,
    PS_DEEPER = 3'd5
  } pwrState_e;

  localparam int NUM_STATES = 6;

  typedef struct packed {
    logic loadCnt;
    logic clrCnt;
    logic decCnt;
    logic saveQs;
    logic saveHalt;
    logic setErr;
  } seqStrobe_t;
endpackage

// File: rtl/pwr_seq_dp.sv
module pwr_seq_dp
  import pwr_seq_pkg::*;
#(
  parameter int RELOCK_CYCLES = 1500,
  parameter int CNT_W = 11
) (
  input  logic       clk,
  input  logic       rst,
  input  seqStrobe_t strobe,
  output logic       cntOne,
  output logic       relocking,
  output logic       retQs,
  output logic       errFlag
);
  logic [CNT_W-1:0] relockCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      relockCnt <= '0;
    end else if (strobe.clrCnt) begin
      relockCnt <= '0;
    end else if (strobe.loadCnt) begin
      relockCnt <= CNT_W'(RELOCK_CYCLES);
    end else if (strobe.decCnt && relockCnt != '0) begin
      relockCnt <= relockCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      retQs   <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      if (strobe.saveQs) retQs <= 1'b1;
      else if (strobe.saveHalt) retQs <= 1'b0;
      if (strobe.setErr) errFlag <= 1'b1;
    end
  end

  assign relocking = (relockCnt != '0);
  assign cntOne    = (relockCnt == CNT_W'(1));
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       haltReq,
  input  logic       quickReq,
  input  logic       snoopReq,
  input  logic       snoopDone,
  input  logic       busClkRun,
  input  logic       deepSleepN,
  input  logic       lowVoltOk,
  input  logic       cntOne,
  input  logic       relocking,
  input  logic       retQs,
  output seqStrobe_t strobe,
  output logic [NUM_STATES-1:0] stateOneHot,
  output logic       snoopOk,
  output logic       coreClkEn,
  output logic       vrLowReq
);
  pwrState_e curState, nxtState;
  logic anyTrig, bothTrig;

  assign anyTrig  = !busClkRun || !deepSleepN;
  assign bothTrig = !busClkRun && !deepSleepN;

  always_ff @(posedge clk) begin
    if (rst) curState <= PS_NORMAL;
    else     curState <= nxtState;
  end

  always_comb begin
    nxtState = curState;
    strobe   = '0;
    case (curState)
      PS_NORMAL: begin
        if (quickReq)     nxtState = PS_QUICK;
        else if (haltReq) nxtState = PS_HALT;
      end
      PS_HALT: begin
        if (snoopReq) begin
          nxtState        = PS_SNOOP;
          strobe.saveHalt = 1'b1;
        end else if (!haltReq) begin
          nxtState = PS_NORMAL;
        end
      end
      PS_QUICK: begin
        if (snoopReq) begin
          nxtState      = PS_SNOOP;
          strobe.saveQs = 1'b1;
        end else if (bothTrig) begin
          strobe.setErr = 1'b1;
        end else if (anyTrig) begin
          nxtState = PS_DEEP;
        end else if (!quickReq) begin
          nxtState = PS_NORMAL;
        end
      end
      PS_SNOOP: begin
        if (retQs && anyTrig) strobe.setErr = 1'b1;
        if (snoopDone) nxtState = retQs ? PS_QUICK : PS_HALT;
      end
      PS_DEEP: begin
        if (snoopReq) strobe.setErr = 1'b1;
        if (relocking) begin
          if (anyTrig) begin
            strobe.clrCnt = 1'b1;
          end else begin
            strobe.decCnt = 1'b1;
            if (cntOne) nxtState = PS_QUICK;
          end
        end else if (!anyTrig) begin
          strobe.loadCnt = 1'b1;
        end else if (lowVoltOk) begin
          nxtState = PS_DEEPER;
        end
      end
      PS_DEEPER: begin
        if (snoopReq) strobe.setErr = 1'b1;
        if (!lowVoltOk) nxtState = PS_DEEP;
      end
      default: nxtState = PS_NORMAL;
    endcase
  end

  for (genvar i = 0; i < NUM_STATES; i++) begin : g_onehot
    assign stateOneHot[i] = (curState == pwrState_e'(i));
  end

  assign coreClkEn = (curState == PS_NORMAL);
  assign snoopOk   = !(curState == PS_DEEP || curState == PS_DEEPER);
  assign vrLowReq  = anyTrig &&
                     ((curState == PS_DEEP && !relocking) || curState == PS_DEEPER);
endmodule

// File: rtl/pwr_state_seq.sv
module pwr_state_seq
  import pwr_seq_pkg::*;
#(
  parameter int RELOCK_CYCLES = 1500
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       haltReq,
  input  logic       quickReq,
  input  logic       snoopReq,
  input  logic       snoopDone,
  input  logic       busClkRun,
  input  logic       deepSleepN,
  input  logic       lowVoltOk,
  output logic [5:0] stateOneHot,
  output logic       snoopOk,
  output logic       coreClkEn,
  output logic       vrLowReq,
  output logic       errFlag
);
  localparam int CNT_W = $clog2(RELOCK_CYCLES + 1);

  seqStrobe_t strobe;
  logic cntOne, relocking, retQs;

  pwr_seq_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .haltReq(haltReq), .quickReq(quickReq),
    .snoopReq(snoopReq), .snoopDone(snoopDone),
    .busClkRun(busClkRun), .deepSleepN(deepSleepN), .lowVoltOk(lowVoltOk),
    .cntOne(cntOne), .relocking(relocking), .retQs(retQs),
    .strobe(strobe), .stateOneHot(stateOneHot),
    .snoopOk(snoopOk), .coreClkEn(coreClkEn), .vrLowReq(vrLowReq)
  );

  pwr_seq_dp #(.RELOCK_CYCLES(RELOCK_CYCLES), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .cntOne(cntOne), .relocking(relocking), .retQs(retQs), .errFlag(errFlag)
  );
endmodule

// File: rtl/pwr_state_seq_chk.sv
module pwr_state_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       snoopReq,
  input logic       snoopDone,
  input logic       busClkRun,
  input logic       deepSleepN,
  input logic [5:0] stateOneHot,
  input logic       errFlag
);
  logic trigAny, trigBoth;
  assign trigAny  = !busClkRun || !deepSleepN;
  assign trigBoth = !busClkRun && !deepSleepN;

  AST_ONE_STATE: assert property (@(posedge clk) disable iff (rst)
    $countones(stateOneHot) == 1); // R1

  AST_SNOOP_ENTER: assert property (@(posedge clk) disable iff (rst)
    ((stateOneHot[1] || stateOneHot[2]) && snoopReq) |=> stateOneHot[3]); // R3

  AST_SNOOP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (stateOneHot[3] && !snoopDone) |=> stateOneHot[3]); // R4

  AST_SNOOP_EXIT: assert property (@(posedge clk) disable iff (rst)
    (stateOneHot[3] && snoopDone) |=> (stateOneHot[1] || stateOneHot[2])); // R4

  AST_DUAL_TRIG: assert property (@(posedge clk) disable iff (rst)
    (stateOneHot[2] && !snoopReq && trigBoth) |=> (stateOneHot[2] && errFlag)); // R6

  AST_WAKE_NEEDS_RELEASE: assert property (@(posedge clk) disable iff (rst)
    ($rose(stateOneHot[2]) && $past(stateOneHot[4])) |-> !$past(trigAny)); // R7

  AST_DEEPER_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    $rose(stateOneHot[5]) |-> $past(stateOneHot[4])); // R8

  AST_DEEP_SNOOP_IGNORED: assert property (@(posedge clk) disable iff (rst)
    ((stateOneHot[4] || stateOneHot[5]) && snoopReq) |=> (errFlag && !stateOneHot[3])); // R9

  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (stateOneHot == 6'b000001 && !errFlag)); // R10

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    errFlag |=> errFlag); // R12
endmodule

bind pwr_state_seq pwr_state_seq_chk u_chk (
  .clk(clk), .rst(rst), .snoopReq(snoopReq), .snoopDone(snoopDone),
  .busClkRun(busClkRun), .deepSleepN(deepSleepN),
  .stateOneHot(stateOneHot), .errFlag(errFlag)
);

// File: tb/pwr_state_seq_test.sv
`timescale 1ns/1ps
module pwr_state_seq_test;
  localparam int RELOCK = 5;
  localparam logic [5:0] ST_N  = 6'b000001;
  localparam logic [5:0] ST_AH = 6'b000010;
  localparam logic [5:0] ST_QS = 6'b000100;
  localparam logic [5:0] ST_SN = 6'b001000;
  localparam logic [5:0] ST_DP = 6'b010000;
  localparam logic [5:0] ST_DR = 6'b100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic haltReq = 0, quickReq = 0, snoopReq = 0, snoopDone = 0;
  logic busClkRun = 1, deepSleepN = 1, lowVoltOk = 0;
  logic [5:0] stateOneHot;
  logic snoopOk, coreClkEn, vrLowReq, errFlag;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  typedef struct {
    logic [5:0] st;
    logic       err;
    logic       vr;
    string      tag;
  } expItem_t;
  expItem_t expQ[$];

  always #10 clk = ~clk;

  pwr_state_seq #(.RELOCK_CYCLES(RELOCK)) uut (
    .clk(clk), .rst(rst), .haltReq(haltReq), .quickReq(quickReq),
    .snoopReq(snoopReq), .snoopDone(snoopDone), .busClkRun(busClkRun),
    .deepSleepN(deepSleepN), .lowVoltOk(lowVoltOk),
    .stateOneHot(stateOneHot), .snoopOk(snoopOk), .coreClkEn(coreClkEn),
    .vrLowReq(vrLowReq), .errFlag(errFlag)
  );

  // monitor: samples 5 ns after each rising edge
  always @(posedge clk) begin
    #5;
    if (expQ.size() > 0) begin
      automatic expItem_t it = expQ.pop_front();
      automatic logic expClk = (it.st == ST_N);               // R11
      automatic logic expSnp = !(it.st == ST_DP || it.st == ST_DR); // R11
      checks++;
      if (stateOneHot !== it.st || errFlag !== it.err || vrLowReq !== it.vr ||
          coreClkEn !== expClk || snoopOk !== expSnp) begin
        errors++;
        $display("FAIL %s: state=%b err=%b vr=%b clk=%b snp=%b expected state=%b err=%b vr=%b clk=%b snp=%b",
                 it.tag, stateOneHot, errFlag, vrLowReq, coreClkEn, snoopOk,
                 it.st, it.err, it.vr, expClk, expSnp);
      end
    end
  end

  task automatic step(input logic h, q, s, d, bc, dn, lv,
                      input logic [5:0] st, input logic e, input logic vr,
                      input string tag);
    @(negedge clk);
    rst = 0; haltReq = h; quickReq = q; snoopReq = s; snoopDone = d;
    busClkRun = bc; deepSleepN = dn; lowVoltOk = lv;
    expQ.push_back('{st, e, vr, tag});
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1; haltReq = 0; quickReq = 0; snoopReq = 0; snoopDone = 0;
    busClkRun = 1; deepSleepN = 1; lowVoltOk = 0;
    expQ.push_back('{ST_N, 1'b0, 1'b0, "R10 reset"});
  endtask

  initial begin
    // Phase A: legal traffic
    doReset();
    step(1,0,0,0,1,1,0, ST_AH, 0, 0, "R2 halt entry");
    step(1,0,1,0,1,1,0, ST_SN, 0, 0, "R3 snoop from halt");
    step(1,0,0,0,1,1,0, ST_SN, 0, 0, "R4 snoop hold");
    step(1,0,0,1,1,1,0, ST_AH, 0, 0, "R4 return to halt");
    step(0,0,0,0,1,1,0, ST_N,  0, 0, "R2 halt exit");
    step(1,1,0,0,1,1,0, ST_QS, 0, 0, "R2 quick priority");
    step(0,1,1,0,1,1,0, ST_SN, 0, 0, "R3 snoop from quick");
    step(0,1,0,1,1,1,0, ST_QS, 0, 0, "R4 return to quick");
    step(0,1,0,0,0,1,0, ST_DP, 0, 1, "R6 deep by clock stop");
    step(0,1,0,0,0,1,1, ST_DR, 0, 1, "R8 deeper entry");
    step(0,1,0,0,1,1,1, ST_DR, 0, 0, "R8 deeper hold, vr drop");
    step(0,1,0,0,1,1,0, ST_DP, 0, 0, "R8 deeper exit");
    for (int i = 0; i < RELOCK; i++)
      step(0,1,0,0,1,1,0, ST_DP, 0, 0, "R7 relock window");
    step(0,1,0,0,1,1,0, ST_QS, 0, 0, "R7 relock done");
    step(0,1,0,0,1,0,0, ST_DP, 0, 1, "R6 deep by pin");
    for (int i = 0; i < RELOCK; i++)
      step(0,1,0,0,1,1,0, ST_DP, 0, 0, "R7 relock window pin");
    step(0,1,0,0,1,1,0, ST_QS, 0, 0, "R7 relock done pin");
    step(0,0,0,0,1,1,0, ST_N,  0, 0, "R2 quick exit");
    // Phase B: both triggers
    doReset();
    step(0,1,0,0,1,1,0, ST_QS, 0, 0, "R2 quick entry");
    step(0,1,0,0,0,0,0, ST_QS, 1, 0, "R6 dual trigger");
    step(0,1,0,0,1,1,0, ST_QS, 1, 0, "R12 error sticky");
    // Phase C: snoop while asleep
    doReset();
    step(0,1,0,0,1,1,0, ST_QS, 0, 0, "R2 quick entry");
    step(0,1,0,0,0,1,0, ST_DP, 0, 1, "R6 deep entry");
    step(0,1,1,0,0,1,0, ST_DP, 1, 1, "R9 snoop in deep");
    // Phase D: snoop and trigger in the same cycle
    doReset();
    step(0,1,0,0,1,1,0, ST_QS, 0, 0, "R2 quick entry");
    step(0,1,1,0,0,1,0, ST_SN, 0, 0, "R3 snoop beats trigger");
    step(0,1,0,0,0,1,0, ST_SN, 1, 0, "R5 trigger during snoop");
    step(0,1,0,1,1,1,0, ST_QS, 1, 0, "R4 return after violation");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule